// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date in packed BCD. A free-running enable at the crystal rate (32768 pulses per second by default) is divided down to one advance per second. Each advance steps seconds, and a rollover ripples through minutes, hours, day of week, day of month, month and a two-digit year. The month length follows the month and, for February, a leap rule of "year divisible by four". Hours count either in 24-hour form or in 12-hour form with an AM/PM flag.

A halt bit in the seconds register freezes all counting. It comes out of reset set, so the clock does not count until software writes the seconds register with that bit clear. Software loads any register through a one-cycle parallel write port and reads any register through a combinational read port. The counters accept any written bit pattern and keep stepping it until it reaches the field's rollover value.

Top module: `rtcc_top`

## Requirements
- R1: After reset the registers read as follows. Address 0 (seconds, bit 7 = halt) reads 0x80. Address 1 (minutes) reads 0x00. Address 2 (hours) reads 0x00. Address 3 (weekday) reads 0x01. Address 4 (date) reads 0x01. Address 5 (month) reads 0x01. Address 6 (year) reads 0x00. Address 7 always reads 0x00.
- R2: While seconds bit 7 is 1, `sec_tick` stays low and no register changes except through a write. Writes are still accepted while halted.
- R3: While running, `sec_tick` is high for one cycle on every TICKS_PER_SEC-th cycle that has `osc_en` high. Cycles with `osc_en` low are not counted.
- R4: A write to address 0 clears the prescaler. The first advance after the write comes on the TICKS_PER_SEC-th enabled cycle after the write cycle.
- R5: Seconds roll from 0x59 to 0x00 and carry into minutes. Minutes roll from 0x59 to 0x00 and carry into hours. The weekday and date do not change on these carries.
- R6: With hours bit 6 = 0 (24-hour form), hours roll from 0x23 to 0x00 and carry into the weekday and date.
- R7: With hours bit 6 = 1 (12-hour form, bit 5 = PM, bits 4:0 = BCD hour), the hour runs 12, 01 … 11. The step from 11 to 12 toggles PM. Only the step from 11 PM to 12 AM carries into the day.
- R8: The weekday advances only on a day carry, counting 1 to 7 and wrapping from 7 back to 1.
- R9: The last date of a month is 0x30 for months 0x04, 0x06, 0x09 and 0x11. It is 0x29 for month 0x02 when the BCD year is divisible by four (including 00), and 0x28 otherwise. It is 0x31 for every other month. The date then returns to 0x01 and the month increments.
- R10: On a day carry from 0x31 in month 0x12, the date goes to 0x01, the month to 0x01 and the year increments. The year wraps from 0x99 to 0x00.
- R11: A written value that is not valid BCD is stepped, not rejected. The low digit counts in binary and rollover happens only at the exact maximum. For example, seconds 0x5D become 0x5E with no carry into minutes.
- R12: When a write and an advance fall in the same cycle, the addressed register takes the written value. All other registers advance from their values before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per crystal period (32768 Hz rate) |
| wr_en | input | 1 | Write strobe, one register per cycle |
| wr_addr | input | 3 | Register address for a write |
| wr_data | input | 8 | Data to write |
| rd_addr | input | 3 | Register address for a read |
| rd_data | output | 8 | Contents of the addressed register (combinational) |
| sec_tick | output | 1 | High in the cycle whose edge advances the time |

## Verification
A register write and the once-per-second advance can land on the same clock edge. The bench provokes this by reloading seconds, which restarts the prescaler at a known phase. It then counts enabled cycles so that a minutes write hits the very edge on which seconds roll from 59. The collision is judged correct when the minutes register holds the written value instead of the carried one, while seconds still show the rollover to 00 and hours stay unchanged.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    typedef enum logic [2:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_WDAY  = 3'd3,
        A_DATE  = 3'd4,
        A_MONTH = 3'd5,
        A_YEAR  = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic       halt;
        logic [6:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
    } clock_t;

    typedef struct packed {
        logic [7:0] wday;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } cal_t;

    // Step a packed BCD byte; the low digit carries only from exactly 9.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = v[7:4];
        lo = v[3:0];
        if (lo == 4'h9) begin
            hi = hi + 4'h1;
            lo = 4'h0;
        end else begin
            lo = lo + 4'h1;
        end
        return {hi, lo};
    endfunction

    // A two-digit BCD year is a multiple of four when the tens digit is even
    // and the units digit is 0, 4 or 8, or the tens digit is odd and the
    // units digit is 2 or 6.
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        else
            return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_prescale.sv
module rtcc_prescale #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && osc_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else if (run && osc_en)
            cnt <= cnt + 1'b1;
    end

    // R4
    restart_gap_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !tick);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rtcc_clock.sv
module rtcc_clock
    import rtcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  reg_addr_e  wr_addr,
    input  logic [7:0] wr_data,
    output clock_t     q,
    output logic       day_carry
);
    logic [7:0] sec_stepped;
    logic [7:0] min_stepped;
    logic [7:0] hour_stepped;
    logic       sec_roll;
    logic       min_roll;
    logic       hour_last;
    logic [7:0] sec_n;
    logic [7:0] min_n;
    logic [7:0] hour_n;

    always_comb begin
        sec_stepped  = bcd_step({1'b0, q.sec});
        min_stepped  = bcd_step(q.min);
        hour_stepped = bcd_step(q.hour);
        sec_roll     = (q.sec == 7'h59);
        min_roll     = sec_roll && (q.min == 8'h59);
        sec_n        = sec_roll ? 8'h00 : sec_stepped;
        min_n        = (q.min == 8'h59) ? 8'h00 : min_stepped;
        if (q.hour[6]) begin
            hour_last = (q.hour[4:0] == 5'h11) && q.hour[5];
            if (q.hour[4:0] == 5'h12)
                hour_n = {q.hour[7:5], 5'h01};
            else if (q.hour[4:0] == 5'h11)
                hour_n = {q.hour[7:6], ~q.hour[5], 5'h12};
            else
                hour_n = {q.hour[7:5], hour_stepped[4:0]};
        end else begin
            hour_last = (q.hour[5:0] == 6'h23);
            hour_n    = hour_last ? {q.hour[7:6], 6'h00}
                                  : {q.hour[7:6], hour_stepped[5:0]};
        end
        day_carry = tick && min_roll && hour_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.halt <= 1'b1;
            q.sec  <= 7'h00;
            q.min  <= 8'h00;
            q.hour <= 8'h00;
        end else begin
            if (tick) begin
                q.sec <= sec_n[6:0];
                if (sec_roll) q.min  <= min_n;
                if (min_roll) q.hour <= hour_n;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_SEC: begin
                        q.halt <= wr_data[7];
                        q.sec  <= wr_data[6:0];
                    end
                    A_MIN:   q.min  <= wr_data;
                    A_HOUR:  q.hour <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // R2
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (q.halt && !wr_en) |=> $stable(q));

    // R5
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && q.sec == 7'h59 && !(wr_en && wr_addr == A_SEC)) |=> (q.sec == 7'h00));

    // R6
    hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (day_carry && !q.hour[6] && !(wr_en && wr_addr == A_HOUR)) |=> (q.hour[5:0] == 6'h00));

endmodule

// File: rtl/rtcc_calendar.sv
module rtcc_calendar
    import rtcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       day_tick,
    input  logic       wr_en,
    input  reg_addr_e  wr_addr,
    input  logic [7:0] wr_data,
    output cal_t       q
);
    logic       date_roll;
    logic       month_roll;
    logic [7:0] wday_n;
    logic [7:0] date_n;
    logic [7:0] month_n;
    logic [7:0] year_n;

    always_comb begin
        wday_n     = (q.wday == 8'h07) ? 8'h01 : q.wday + 8'h01;
        date_roll  = (q.date == last_date(q.month, q.year));
        month_roll = date_roll && (q.month == 8'h12);
        date_n     = date_roll ? 8'h01 : bcd_step(q.date);
        month_n    = (q.month == 8'h12) ? 8'h01 : bcd_step(q.month);
        year_n     = (q.year == 8'h99) ? 8'h00 : bcd_step(q.year);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.wday  <= 8'h01;
            q.date  <= 8'h01;
            q.month <= 8'h01;
            q.year  <= 8'h00;
        end else begin
            if (day_tick) begin
                q.wday <= wday_n;
                q.date <= date_n;
                if (date_roll)  q.month <= month_n;
                if (month_roll) q.year  <= year_n;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_WDAY:  q.wday  <= wr_data;
                    A_DATE:  q.date  <= wr_data;
                    A_MONTH: q.month <= wr_data;
                    A_YEAR:  q.year  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // R8
    wday_range_chk: assert property (@(posedge clk) disable iff (rst)
        (day_tick && q.wday >= 8'h01 && q.wday <= 8'h07 && !(wr_en && wr_addr == A_WDAY))
        |=> (q.wday >= 8'h01 && q.wday <= 8'h07));

    // R10
    year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (day_tick && q.month == 8'h12 && q.date == 8'h31 && q.year == 8'h99 && !wr_en)
        |=> (q.year == 8'h00 && q.month == 8'h01 && q.date == 8'h01));

    // R8
    wday_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!day_tick && !wr_en) |=> $stable(q.wday));

endmodule

// File: rtl/rtcc_top.sv
module rtcc_top
    import rtcc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       sec_tick
);
    reg_addr_e waddr;
    clock_t    clk_q;
    cal_t      cal_q;
    logic      day_carry;
    logic      sec_wr;

    assign waddr  = reg_addr_e'(wr_addr);
    assign sec_wr = wr_en && (waddr == A_SEC);

    rtcc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .osc_en (osc_en),
        .run    (!clk_q.halt),
        .clr    (sec_wr),
        .tick   (sec_tick)
    );

    rtcc_clock u_clock (
        .clk       (clk),
        .rst       (rst),
        .tick      (sec_tick),
        .wr_en     (wr_en),
        .wr_addr   (waddr),
        .wr_data   (wr_data),
        .q         (clk_q),
        .day_carry (day_carry)
    );

    rtcc_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .day_tick (day_carry),
        .wr_en    (wr_en),
        .wr_addr  (waddr),
        .wr_data  (wr_data),
        .q        (cal_q)
    );

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_SEC:   rd_data = {clk_q.halt, clk_q.sec};
            A_MIN:   rd_data = clk_q.min;
            A_HOUR:  rd_data = clk_q.hour;
            A_WDAY:  rd_data = cal_q.wday;
            A_DATE:  rd_data = cal_q.date;
            A_MONTH: rd_data = cal_q.month;
            A_YEAR:  rd_data = cal_q.year;
            default: rd_data = 8'h00;
        endcase
    end

    // R2
    tick_halt_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> !clk_q.halt);

    // R12
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && waddr == A_MIN) |=> (clk_q.min == $past(wr_data)));

endmodule

// File: tb/test_rtcc_top.sv
module test_rtcc_top;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       sec_tick;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtcc_top #(.TICKS_PER_SEC(TPS)) i_rtcc_top (
        .clk      (clk),
        .rst      (rst),
        .osc_en   (osc_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sec_tick (sec_tick)
    );

    always @(negedge clk) if (!rst && sec_tick) tick_cnt++;

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: addr %0d got %02h expected %02h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Halt, load everything, then release; ends with the prescaler just cleared.
    task automatic setup(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                         input logic [7:0] y);
        wr(3'd0, 8'h80);
        wr(3'd1, m); wr(3'd2, h); wr(3'd3, w);
        wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
        wr(3'd0, s);
    endtask

    task automatic run_secs(input int n);
        repeat (n * TPS) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(3'd0, 8'h80, "R1 sec"); chk(3'd1, 8'h00, "R1 min");
        chk(3'd2, 8'h00, "R1 hour"); chk(3'd3, 8'h01, "R1 wday");
        chk(3'd4, 8'h01, "R1 date"); chk(3'd5, 8'h01, "R1 month");
        chk(3'd6, 8'h00, "R1 year"); chk(3'd7, 8'h00, "R1 unused");
    endtask

    task automatic t_halt;
        repeat (12) @(negedge clk);
        chk(3'd0, 8'h80, "R2 halted sec");
        chk_bit(tick_cnt == 0, 1'b1, "R2 no tick while halted");
        wr(3'd1, 8'h07);
        repeat (12) @(negedge clk);
        chk(3'd1, 8'h07, "R2 write accepted while halted");
        setup(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        run_secs(2);
        wr(3'd0, 8'h85);
        repeat (12) @(negedge clk);
        chk(3'd0, 8'h85, "R2 re-halted sec");
        chk(3'd1, 8'h00, "R2 re-halted min");
    endtask

    task automatic t_rate;
        setup(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        osc_en = 1'b0;
        repeat (2) @(negedge clk);
        osc_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(3'd0, 8'h10, "R3 gated enables not counted");
        chk_bit(sec_tick, 1'b1, "R3 tick on 4th enabled cycle");
        @(negedge clk);
        chk(3'd0, 8'h11, "R3 advance");
        chk_bit(sec_tick, 1'b0, "R3 tick is one cycle");
    endtask

    task automatic t_restart;
        setup(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        repeat (2) @(negedge clk);
        wr(3'd0, 8'h30);
        repeat (3) @(negedge clk);
        chk(3'd0, 8'h30, "R4 prescaler cleared by write");
        @(negedge clk);
        chk(3'd0, 8'h31, "R4 full second after write");
    endtask

    task automatic t_carry;
        setup(8'h59, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
        run_secs(1);
        chk(3'd0, 8'h00, "R5 sec wrap"); chk(3'd1, 8'h00, "R5 min wrap");
        chk(3'd2, 8'h06, "R5 hour carry"); chk(3'd3, 8'h02, "R5 wday unchanged");
        chk(3'd4, 8'h10, "R5 date unchanged");
    endtask

    task automatic t_24h;
        setup(8'h59, 8'h59, 8'h23, 8'h03, 8'h14, 8'h05, 8'h21);
        run_secs(1);
        chk(3'd2, 8'h00, "R6 23 to 00"); chk(3'd3, 8'h04, "R6 wday carry");
        chk(3'd4, 8'h15, "R6 date carry");
    endtask

    task automatic t_12h;
        setup(8'h59, 8'h59, 8'h71, 8'h03, 8'h14, 8'h05, 8'h21);
        run_secs(1);
        chk(3'd2, 8'h52, "R7 11PM to 12AM"); chk(3'd4, 8'h15, "R7 day carry at 12AM");
        setup(8'h59, 8'h59, 8'h51, 8'h03, 8'h14, 8'h05, 8'h21);
        run_secs(1);
        chk(3'd2, 8'h72, "R7 11AM to 12PM"); chk(3'd4, 8'h14, "R7 no day carry at noon");
        setup(8'h59, 8'h59, 8'h52, 8'h03, 8'h14, 8'h05, 8'h21);
        run_secs(1);
        chk(3'd2, 8'h41, "R7 12 to 01 keeps AM");
        setup(8'h59, 8'h59, 8'h49, 8'h03, 8'h14, 8'h05, 8'h21);
        run_secs(1);
        chk(3'd2, 8'h50, "R7 09 to 10");
    endtask

    task automatic t_wday;
        setup(8'h59, 8'h59, 8'h23, 8'h07, 8'h14, 8'h05, 8'h21);
        run_secs(1);
        chk(3'd3, 8'h01, "R8 wday 7 to 1");
    endtask

    task automatic t_month;
        setup(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
        run_secs(1);
        chk(3'd4, 8'h01, "R9 Apr 30 date"); chk(3'd5, 8'h05, "R9 Apr 30 month");
        setup(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h21);
        run_secs(1);
        chk(3'd4, 8'h31, "R9 Jan 30 to 31");
        setup(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        run_secs(1);
        chk(3'd5, 8'h03, "R9 Feb 28 common year");
        setup(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        run_secs(1);
        chk(3'd4, 8'h29, "R9 Feb 29 in 24");
        setup(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        run_secs(1);
        chk(3'd4, 8'h29, "R9 Feb 29 in 00");
        setup(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h16);
        run_secs(1);
        chk(3'd4, 8'h29, "R9 Feb 29 in 16");
        setup(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h21);
        run_secs(1);
        chk(3'd5, 8'h12, "R9 Nov 30 month");
    endtask

    task automatic t_year;
        setup(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        run_secs(1);
        chk(3'd4, 8'h01, "R10 date"); chk(3'd5, 8'h01, "R10 month");
        chk(3'd6, 8'h00, "R10 year 99 to 00");
        setup(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h19);
        run_secs(1);
        chk(3'd6, 8'h20, "R10 year 19 to 20");
    endtask

    task automatic t_invalid;
        setup(8'h5D, 8'h12, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
        run_secs(1);
        chk(3'd0, 8'h5E, "R11 invalid sec steps");
        chk(3'd1, 8'h12, "R11 no carry from invalid");
    endtask

    task automatic t_collide;
        setup(8'h59, 8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
        repeat (3) @(negedge clk);
        wr(3'd1, 8'h42);
        chk(3'd0, 8'h00, "R12 sec still advances");
        chk(3'd1, 8'h42, "R12 write wins over carry");
        chk(3'd2, 8'h10, "R12 hour unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_halt;
        t_rate;
        t_restart;
        t_carry;
        t_24h;
        t_12h;
        t_wday;
        t_month;
        t_year;
        t_invalid;
        t_collide;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule